// File: doc/BRIEF.md
# Transmit Byte Queue with Selectable Request Conditions

This block is a small byte queue placed between a processor or DMA write port and a serial transmitter. Bytes written on the write port are held in arrival order and presented one at a time to the shifter, which takes the oldest byte with a read strobe. The block tracks how many bytes it holds and, from that, drives a buffer-empty status flag, a fully-empty flag, an interrupt request and a DMA request.

The buffer-empty flag describes the entry location, not the whole queue. It is high whenever a write can be accepted, which means fewer than four bytes are held. The interrupt request and the DMA request each have a mode bit that chooses their trigger. The trigger is either "entry location empty" or "whole queue empty". Each request is also gated by its own enable. The DMA request drops in the same cycle as the write that removes its condition, so a DMA engine does not issue one write too many. A write into a full queue is discarded and sets a sticky overflow flag, which a separate clear strobe resets.

Occupancy is held by a three-state machine:
- States:
  - `ST_EMPTY`: no bytes held.
  - `ST_PART`: one to three bytes held.
  - `ST_FULL`: four bytes held.
- Named transitions:
  - FILL_FIRST (`ST_EMPTY`→`ST_PART`): a write is accepted.
  - DRAIN_LAST (`ST_PART`→`ST_EMPTY`): a lone read takes the last byte.
  - TOP_OFF (`ST_PART`→`ST_FULL`): a lone write fills the last slot.
  - UNLOAD (`ST_FULL`→`ST_PART`): a read occurs.
- Every other case stays in its current state. This includes a write and a read in the same cycle in `ST_PART`.

Top module: `txq_req_top`

## Requirements
- R1: After reset the queue is empty: `buf_empty`=1, `all_empty`=1, `tx_valid`=0 and `overflow`=0.
- R2: Bytes leave in the order they were written. `tx_data` shows the oldest byte, and `tx_valid` is 1 whenever at least one byte is held.
- R3: `buf_empty` is 1 exactly when fewer than four bytes are held. `all_empty` is 1 exactly when zero bytes are held.
- R4: A write while four bytes are held is ignored, so occupancy and queue contents are unchanged by it. The next cycle, `overflow` reads 1.
- R5: `overflow` stays 1 until a cycle with `ovf_clr`=1, after which it reads 0. A new overflow in the same cycle as the clear wins, and the flag stays 1.
- R6: A read while the queue is empty has no effect, and occupancy stays zero.
- R7: `irq` = `irq_en` AND the selected condition. With `irq_mode`=0 the condition is `buf_empty`; with `irq_mode`=1 it is `all_empty`.
- R8: `dma_req` = `dma_en` AND the condition selected by `dma_mode`, with the same encoding as R7. It is forced to 0 during any cycle whose accepted write will remove that condition.
- R9: A write and a read in the same cycle while one to three bytes are held leave the occupancy unchanged. The new byte goes to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from processor or DMA |
| wr_data | input | 8 | Byte to enqueue |
| rd_en | input | 1 | Read strobe from the shifter |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| irq_mode | input | 1 | 0: interrupt on entry empty, 1: on all empty |
| dma_mode | input | 1 | 0: DMA request on entry empty, 1: on all empty |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| tx_data | output | 8 | Oldest byte held |
| tx_valid | output | 1 | At least one byte held |
| buf_empty | output | 1 | Entry location free (fewer than four bytes) |
| all_empty | output | 1 | No bytes held |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| overflow | output | 1 | Sticky flag for a write lost while full |

## Verification
A wrong occupancy state shows up within the same cycle on `buf_empty`, `all_empty`, `tx_valid` and both requests. It also shows up one read later as a wrong or missing byte on `tx_data`. A pointer error leaves the flags correct but gives a byte out of order as soon as the affected slot reaches the head. The DMA look-ahead can only be seen in the cycle of the write itself, so the requests are sampled after the inputs are driven and before the clock edge.

// File: rtl/txq_req_pkg.sv
package txq_req_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_t;

    typedef enum logic {
        REQ_ON_ENTRY = 1'b0,
        REQ_ON_ALL   = 1'b1
    } req_mode_t;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [WIDTH-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (push && (wr_ptr_q == PTR_W'(i))) begin
                slot_q[i] <= din;
            end
        end
    end

    assign dout = slot_q[rd_ptr_q];

endmodule

// File: rtl/txq_occ_fsm.sv
module txq_occ_fsm
    import txq_req_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic       rd_req,
    input  logic       ovf_clr,
    output logic       push,
    output logic       pop,
    output logic       buf_empty,
    output logic       all_empty,
    output logic       nxt_buf_empty,
    output logic       nxt_all_empty,
    output logic       overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             ovf_q;
    logic             ovf_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (ovf_hit)      ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    // next state: named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_PART;                              // FILL_FIRST
            end
            ST_PART: begin
                if (push && !pop && count_q == FULL_CNT - ONE_CNT)
                    state_d = ST_FULL;                                    // TOP_OFF
                else if (pop && !push && count_q == ONE_CNT)
                    state_d = ST_EMPTY;                                   // DRAIN_LAST
            end
            ST_FULL: begin
                if (pop) state_d = ST_PART;                               // UNLOAD
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        push          = wr_req && (state_q != ST_FULL);
        pop           = rd_req && (state_q != ST_EMPTY);
        ovf_hit       = wr_req && (state_q == ST_FULL);
        buf_empty     = (state_q != ST_FULL);
        all_empty     = (state_q == ST_EMPTY);
        nxt_buf_empty = (state_d != ST_FULL);
        nxt_all_empty = (state_d == ST_EMPTY);
        overflow      = ovf_q;
        unique case ({push, pop})
            2'b10:   count_d = count_q + ONE_CNT;
            2'b01:   count_d = count_q - ONE_CNT;
            default: count_d = count_q;
        endcase
    end

endmodule

// File: rtl/txq_req_gen.sv
module txq_req_gen
    import txq_req_pkg::*;
(
    input  logic irq_mode,
    input  logic dma_mode,
    input  logic irq_en,
    input  logic dma_en,
    input  logic buf_empty,
    input  logic all_empty,
    input  logic nxt_buf_empty,
    input  logic nxt_all_empty,
    output logic irq,
    output logic dma_req
);
    req_mode_t irq_sel, dma_sel;
    logic      dma_now, dma_nxt;

    always_comb begin
        irq_sel = req_mode_t'(irq_mode);
        dma_sel = req_mode_t'(dma_mode);
        unique case (irq_sel)
            REQ_ON_ENTRY: irq = irq_en && buf_empty;
            REQ_ON_ALL:   irq = irq_en && all_empty;
            default:      irq = 1'b0;
        endcase
        unique case (dma_sel)
            REQ_ON_ENTRY: begin dma_now = buf_empty; dma_nxt = nxt_buf_empty; end
            REQ_ON_ALL:   begin dma_now = all_empty; dma_nxt = nxt_all_empty; end
            default:      begin dma_now = 1'b0;      dma_nxt = 1'b0;          end
        endcase
        dma_req = dma_en && dma_now && dma_nxt;
    end

endmodule

// File: rtl/txq_req_top.sv
module txq_req_top
    import txq_req_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             ovf_clr,
    input  logic             irq_mode,
    input  logic             dma_mode,
    input  logic             irq_en,
    input  logic             dma_en,
    output logic [WIDTH-1:0] tx_data,
    output logic             tx_valid,
    output logic             buf_empty,
    output logic             all_empty,
    output logic             irq,
    output logic             dma_req,
    output logic             overflow
);
    logic push, pop, nxt_buf_empty, nxt_all_empty;

    txq_occ_fsm #(.DEPTH(DEPTH)) occ_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_req        (wr_en),
        .rd_req        (rd_en),
        .ovf_clr       (ovf_clr),
        .push          (push),
        .pop           (pop),
        .buf_empty     (buf_empty),
        .all_empty     (all_empty),
        .nxt_buf_empty (nxt_buf_empty),
        .nxt_all_empty (nxt_all_empty),
        .overflow      (overflow)
    );

    txq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .dout  (tx_data)
    );

    txq_req_gen req_i (
        .irq_mode      (irq_mode),
        .dma_mode      (dma_mode),
        .irq_en        (irq_en),
        .dma_en        (dma_en),
        .buf_empty     (buf_empty),
        .all_empty     (all_empty),
        .nxt_buf_empty (nxt_buf_empty),
        .nxt_all_empty (nxt_all_empty),
        .irq           (irq),
        .dma_req       (dma_req)
    );

    assign tx_valid = !all_empty;

endmodule

// File: rtl/txq_req_chk.sv
module txq_req_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic ovf_clr,
    input logic irq_en,
    input logic dma_en,
    input logic dma_mode,
    input logic tx_valid,
    input logic buf_empty,
    input logic all_empty,
    input logic irq,
    input logic dma_req,
    input logic overflow
);
    // R3
    empty_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> (buf_empty && !tx_valid));

    // R4
    full_write_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_empty) |=> overflow);

    // R4
    full_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !buf_empty) |=> !buf_empty);

    // R5
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(wr_en && !buf_empty)) |=> !overflow);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_empty && rd_en && !wr_en) |=> all_empty);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8
    dma_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && !buf_empty) |-> !dma_req);

    // R8
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);
endmodule

bind txq_req_top txq_req_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .ovf_clr   (ovf_clr),
    .irq_en    (irq_en),
    .dma_en    (dma_en),
    .dma_mode  (dma_mode),
    .tx_valid  (tx_valid),
    .buf_empty (buf_empty),
    .all_empty (all_empty),
    .irq       (irq),
    .dma_req   (dma_req),
    .overflow  (overflow)
);

// File: tb/txq_req_top_tb_top.sv
`timescale 1ns/1ps
module txq_req_top_tb_top;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, ovf_clr = 0;
    logic       irq_mode = 0, dma_mode = 0, irq_en = 0, dma_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] tx_data;
    logic       tx_valid, buf_empty, all_empty, irq, dma_req, overflow;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] q[$];
    logic       m_ovf = 1'b0;

    always #4 clk = ~clk;

    txq_req_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .ovf_clr(ovf_clr), .irq_mode(irq_mode), .dma_mode(dma_mode),
        .irq_en(irq_en), .dma_en(dma_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .buf_empty(buf_empty), .all_empty(all_empty), .irq(irq),
        .dma_req(dma_req), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cond_of(input int n, input bit mode);
        return mode ? (n == 0) : (n < DEPTH);
    endfunction

    function automatic int next_n(input int n, input bit w, input bit r);
        int m = n;
        if (w && n < DEPTH) m++;
        if (r && n > 0) m--;
        return m;
    endfunction

    // compare all outputs with the model; called after inputs are driven
    task automatic check_all();
        int n = q.size();
        bit e_dma;
        chk(buf_empty == (n < DEPTH), "R3 buf_empty", buf_empty, n < DEPTH);
        chk(all_empty == (n == 0), "R3 all_empty", all_empty, n == 0);
        chk(tx_valid == (n > 0), "R2 tx_valid", tx_valid, n > 0);
        if (n > 0) chk(tx_data == q[0], "R2 tx_data", tx_data, q[0]);
        chk(overflow == m_ovf, "R4/R5 overflow", overflow, m_ovf);
        chk(irq == (irq_en && cond_of(n, irq_mode)), "R7 irq", irq,
            irq_en && cond_of(n, irq_mode));
        e_dma = dma_en && cond_of(n, dma_mode) && cond_of(next_n(n, wr_en, rd_en), dma_mode);
        chk(dma_req == e_dma, "R8 dma_req", dma_req, e_dma);
    endtask

    task automatic update_model();
        int n = q.size();
        bit full_hit = wr_en && (n >= DEPTH);
        if (rd_en && n > 0) void'(q.pop_front());
        if (wr_en && n < DEPTH) q.push_back(wr_data);
        if (full_hit) m_ovf = 1'b1;
        else if (ovf_clr) m_ovf = 1'b0;
    endtask

    // one cycle: drive at negedge, check, then model follows the posedge
    task automatic step(input bit w, input logic [7:0] d, input bit r, input bit c);
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; ovf_clr = c;
        #1;
        check_all();
        @(posedge clk);
        update_model();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        irq_en = 1; dma_en = 1;
        repeat (3) @(posedge clk);
        // R1 reset state
        @(negedge clk);
        chk(buf_empty && all_empty && !tx_valid && !overflow, "R1 reset", 
            {buf_empty, all_empty, tx_valid, overflow}, 4'b1100);
        rst_n = 1'b1;

        // R6 read while empty
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 0, 0);
        chk(q.size() == 0 && all_empty, "R6 empty read", all_empty, 1);

        // R2 fill with four bytes, R8 dma drops on the filling write (mode 0)
        dma_mode = 0; irq_mode = 1;
        step(1, 8'hA1, 0, 0);
        step(1, 8'hB2, 0, 0);
        step(1, 8'hC3, 0, 0);
        @(negedge clk);
        wr_en = 1; wr_data = 8'hD4; rd_en = 0; ovf_clr = 0; #1;
        chk(dma_req == 0, "R8 dma drops on filling write", dma_req, 0);
        @(posedge clk); update_model();

        // R4 write while full ignored
        step(1, 8'hEE, 0, 0);
        step(0, 8'h00, 0, 0);
        chk(overflow == 1 && tx_data == 8'hA1, "R4 full write ignored", tx_data, 8'hA1);

        // R5 clear with concurrent overflow keeps the flag
        step(1, 8'hEF, 0, 1);
        step(0, 8'h00, 0, 1);
        step(0, 8'h00, 0, 0);
        chk(overflow == 0, "R5 overflow cleared", overflow, 0);

        // R2 drain in order, R9 simultaneous read/write
        step(0, 8'h00, 1, 0);
        step(1, 8'h55, 1, 0);
        chk(q.size() == 3, "R9 occupancy kept", q.size(), 3);
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 0);
        // R8 mode 1: write into empty drops dma in that cycle
        dma_mode = 1;
        step(0, 8'h00, 1, 0);
        @(negedge clk);
        wr_en = 1; wr_data = 8'h77; rd_en = 0; ovf_clr = 0; #1;
        chk(dma_req == 0, "R8 dma drops on first write mode1", dma_req, 0);
        @(posedge clk); update_model();

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                irq_mode = $urandom_range(0, 1); dma_mode = $urandom_range(0, 1);
                irq_en = $urandom_range(0, 3) != 0; dma_en = $urandom_range(0, 3) != 0;
            end
            step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
                 $urandom_range(0, 99) < 5);
        end
        step(0, 8'h00, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule